// File: doc/BRIEF.md
# Memory Interrupt Report Writer

This block reports an interrupt from one of up to 64 hardware units by writing bytes into a report area in memory. It then raises a host interrupt. Each accepted event carries a 16-bit event vector, the unit's index, and an instance number. The unit index is also the unit's bit position in the top-level interrupt word. The bench also supplies a report-area base address, a 16-bit enable mask and a mode select.

For every event bit that is both set and enabled, the block writes one byte of 0xFF into the unit's 16-byte status slot. The status slots are at the bottom of the report page. After those writes, it writes one 0xFF byte into the source region, at offset 0x400 plus the unit index. Only then does it pulse the host interrupt for one cycle.

When per-instance mode is selected, every instance has its own copy of the page at base plus instance × 0x1000. Otherwise all instances share the page at the base address. The block handles one event at a time and holds new events off with its ready output until the pulse is done.

Top module: `irq_report_writer`

## Requirements
- R1: After reset, `evt_ready` is 1, `wr_valid` is 0 and `irq` is 0.
- R2: For each enabled event bit b of unit u, one write is made to page + 16·u + b.
- R3: Event bits whose enable-mask bit is 0 produce no write. An event with no enabled bit set produces no write and no `irq`, and `evt_ready` stays 1.
- R4: Status writes for one event are issued in ascending bit order. The source write comes after all of them.
- R5: The single source write for unit u goes to page + 0x400 + u.
- R6: `irq` is high for exactly one cycle. That cycle directly follows the clock edge at which the source write is accepted (`wr_valid` and `wr_ready` both high).
- R7: With `per_inst_mode` = 1 the page is `base_addr` + `evt_inst` × 0x1000. With `per_inst_mode` = 0 the page is `base_addr`, whatever the value of `evt_inst`.
- R8: `evt_ready` is 0 from the edge that accepts an event until the `irq` cycle ends. Events offered while busy are ignored. While `wr_valid` is 1 and `wr_ready` is 0, `wr_addr` and `wr_valid` hold.
- R9: `wr_data` is 0xFF on every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Block idle, event accepted when valid |
| evt_unit | input | UNIT_W | Unit index (bit in top-level word) |
| evt_vec | input | 16 | Per-unit event bits |
| evt_inst | input | INST_W | Engine instance number |
| per_inst_mode | input | 1 | 1: one page per instance |
| base_addr | input | ADDR_W | Report-area base address |
| en_mask | input | 16 | Event enable mask, 1 = enabled |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts write |
| wr_addr | output | ADDR_W | Byte address of write |
| wr_data | output | 8 | Write data |
| irq | output | 1 | Host interrupt pulse |

## Verification
An event accepted at an edge has its first write on the port right after that edge. Each further write follows the edge at which the previous one was accepted. The `irq` pulse follows the edge that accepts the source write, and `evt_ready` returns one cycle after that. The bench keeps a behavioural model that is stepped once per clock with the same inputs. It compares every output half a cycle after each edge, so each result is checked in exactly the cycle it is due. A stalling `wr_ready` pattern and events offered while the block is busy test the hold and ignore rules.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
    localparam int VEC_W       = 16;
    localparam int BIT_W       = $clog2(VEC_W);
    localparam int SRC_OFS     = 'h400;
    localparam int PAGE_SHIFT  = 12;
    localparam logic [7:0] HIT_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STAT,
        ST_SRC,
        ST_IRQ
    } wr_state_e;
endpackage

// File: rtl/irqw_low_bit.sv
module irqw_low_bit
    import irqw_pkg::*;
(
    input  logic [VEC_W-1:0] vec,
    output logic [BIT_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = VEC_W - 1; i >= 0; i--) begin
            if (vec[i]) idx = BIT_W'(i);
        end
    end
endmodule

// File: rtl/irqw_page_sel.sv
module irqw_page_sel
    import irqw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INST_W = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [INST_W-1:0] inst,
    input  logic              per_inst,
    output logic [ADDR_W-1:0] page
);
    logic [ADDR_W-1:0] inst_ofs;

    always_comb begin
        inst_ofs = ADDR_W'(inst) << PAGE_SHIFT;
        page     = per_inst ? base + inst_ofs : base;
    end
endmodule

// File: rtl/irqw_addr_gen.sv
module irqw_addr_gen
    import irqw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int UNIT_W = 6
) (
    input  logic [ADDR_W-1:0] page,
    input  logic [UNIT_W-1:0] unit,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              is_src,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] stat_ofs;
    logic [ADDR_W-1:0] src_ofs;

    always_comb begin
        stat_ofs = (ADDR_W'(unit) << BIT_W) + ADDR_W'(bit_idx);
        src_ofs  = ADDR_W'(SRC_OFS) + ADDR_W'(unit);
        addr     = page + (is_src ? src_ofs : stat_ofs);
    end
endmodule

// File: rtl/irq_report_writer.sv
module irq_report_writer
    import irqw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INST_W = 4,
    parameter int UNIT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [UNIT_W-1:0] evt_unit,
    input  logic [VEC_W-1:0]  evt_vec,
    input  logic [INST_W-1:0] evt_inst,
    input  logic              per_inst_mode,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [VEC_W-1:0]  en_mask,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              irq
);
    typedef struct packed {
        wr_state_e         st;
        logic [VEC_W-1:0]  pend;
        logic [UNIT_W-1:0] unit;
        logic [ADDR_W-1:0] page;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] new_page;
    logic [BIT_W-1:0]  cur_bit;
    logic [VEC_W-1:0]  masked;
    logic [VEC_W-1:0]  rest;

    irqw_page_sel #(.ADDR_W(ADDR_W), .INST_W(INST_W)) u_page (
        .base     (base_addr),
        .inst     (evt_inst),
        .per_inst (per_inst_mode),
        .page     (new_page)
    );

    irqw_low_bit u_low (
        .vec (r_q.pend),
        .idx (cur_bit)
    );

    irqw_addr_gen #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W)) u_addr (
        .page    (r_q.page),
        .unit    (r_q.unit),
        .bit_idx (cur_bit),
        .is_src  (r_q.st == ST_SRC),
        .addr    (wr_addr)
    );

    always_comb begin
        r_d    = r_q;
        masked = evt_vec & en_mask;
        rest   = r_q.pend & (r_q.pend - VEC_W'(1));
        unique case (r_q.st)
            ST_IDLE: begin
                if (evt_valid) begin
                    r_d.pend = masked;
                    r_d.unit = evt_unit;
                    r_d.page = new_page;
                    if (|masked) r_d.st = ST_STAT;
                end
            end
            ST_STAT: begin
                if (wr_ready) begin
                    r_d.pend = rest;
                    if (rest == '0) r_d.st = ST_SRC;
                end
            end
            ST_SRC:  if (wr_ready) r_d.st = ST_IRQ;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.pend <= '0;
            r_q.unit <= '0;
            r_q.page <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign evt_ready = (r_q.st == ST_IDLE);
    assign wr_valid  = (r_q.st == ST_STAT) || (r_q.st == ST_SRC);
    assign irq       = (r_q.st == ST_IRQ);
    assign wr_data   = wr_valid ? HIT_BYTE : 8'h00;

    // R8: a stalled write keeps its request and address
    a_r8_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

    // R8: no new event is taken while writes are outstanding
    a_r8_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !evt_ready);

    // R6: interrupt is a single-cycle pulse
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: interrupt only after a completed write
    a_r6_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_valid && wr_ready));

    // R4: consecutive writes of one event climb in address
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr > $past(wr_addr))));
endmodule

// File: tb/sim_irq_report_writer.sv
module sim_irq_report_writer;
    localparam int NEV = 30;
    localparam int WD  = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_valid;
    logic        evt_ready;
    logic [5:0]  evt_unit;
    logic [15:0] evt_vec;
    logic [3:0]  evt_inst;
    logic        per_inst_mode;
    logic [31:0] base_addr;
    logic [15:0] en_mask;
    logic        wr_valid;
    logic        wr_ready;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        irq;

    always #2.5 clk = ~clk;

    irq_report_writer u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_unit(evt_unit), .evt_vec(evt_vec), .evt_inst(evt_inst),
        .per_inst_mode(per_inst_mode), .base_addr(base_addr), .en_mask(en_mask),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int mstate = 0;           // 0 idle, 1 writing, 2 irq cycle
    int idx    = 0;
    int cyc    = 0;
    logic [31:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic set_evt(input int i);
        case (i)
            0: begin evt_unit = 0;  evt_vec = 16'h0001; en_mask = 16'hFFFF; per_inst_mode = 0; evt_inst = 0; base_addr = 32'h0001_0000; end
            1: begin evt_unit = 5;  evt_vec = 16'h8421; en_mask = 16'hFFFF; per_inst_mode = 0; evt_inst = 2; base_addr = 32'h0001_0000; end
            2: begin evt_unit = 9;  evt_vec = 16'h00FF; en_mask = 16'h0F0F; per_inst_mode = 0; evt_inst = 0; base_addr = 32'h0002_0000; end // R3 partial
            3: begin evt_unit = 12; evt_vec = 16'hF000; en_mask = 16'h0FFF; per_inst_mode = 1; evt_inst = 1; base_addr = 32'h0002_0000; end // R3 none
            4: begin evt_unit = 63; evt_vec = 16'hFFFF; en_mask = 16'hFFFF; per_inst_mode = 1; evt_inst = 3; base_addr = 32'h0003_0000; end // R7
            5: begin evt_unit = 20; evt_vec = 16'h0102; en_mask = 16'hFFFF; per_inst_mode = 0; evt_inst = 7; base_addr = 32'h0003_0000; end // R7 shared
            6: begin evt_unit = 40; evt_vec = 16'h4000; en_mask = 16'hFFFF; per_inst_mode = 1; evt_inst = 15; base_addr = 32'h0004_0000; end
            default: begin
                evt_unit      = 6'((i * 13) % 64);
                evt_vec       = 16'(i * 16'h3A5B) ^ 16'(i << 3);
                en_mask       = (i % 3 == 0) ? 16'hFFFF : ~(16'h1 << (i % 16));
                per_inst_mode = i[0];
                evt_inst      = 4'(i % 16);
                base_addr     = 32'h0010_0000 + 32'(i) * 32'h0001_0000;
            end
        endcase
    endtask

    task automatic model_accept();
        logic [31:0] page;
        logic [15:0] m;
        page = per_inst_mode ? base_addr + (32'(evt_inst) << 12) : base_addr;  // R7
        m = evt_vec & en_mask;
        for (int b = 0; b < 16; b++)
            if (m[b]) exp_q.push_back(page + 32'(evt_unit) * 16 + 32'(b));   // R2 R4
        if (m != 0) begin
            exp_q.push_back(page + 32'h400 + 32'(evt_unit));                  // R5
            mstate = 1;
        end
    endtask

    initial begin
        bit done;
        done = 0;
        rst_n = 0; evt_valid = 0; wr_ready = 0;
        set_evt(0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(evt_ready == 1'b1, "R1 evt_ready", 32'(evt_ready), 1);
        chk(wr_valid == 1'b0, "R1 wr_valid", 32'(wr_valid), 0);
        chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
        while (!done) begin
            @(negedge clk);
            cyc++;
            // compare against model state after the last edge
            if (mstate == 0) begin
                chk(evt_ready == 1'b1, "R8 evt_ready idle", 32'(evt_ready), 1);
                chk(wr_valid == 1'b0, "R3 wr_valid idle", 32'(wr_valid), 0);
                chk(irq == 1'b0, "R3 irq idle", 32'(irq), 0);
            end else if (mstate == 1) begin
                chk(evt_ready == 1'b0, "R8 evt_ready busy", 32'(evt_ready), 0);
                chk(wr_valid == 1'b1, "R2 wr_valid", 32'(wr_valid), 1);
                chk(wr_addr == exp_q[0], (exp_q.size() == 1) ? "R5 source addr" : "R2 R4 R7 status addr",
                    wr_addr, exp_q[0]);
                chk(wr_data == 8'hFF, "R9 wr_data", 32'(wr_data), 32'hFF);
                chk(irq == 1'b0, "R6 irq early", 32'(irq), 0);
            end else begin
                chk(irq == 1'b1, "R6 irq pulse", 32'(irq), 1);
                chk(wr_valid == 1'b0, "R6 wr_valid in irq", 32'(wr_valid), 0);
                chk(evt_ready == 1'b0, "R8 evt_ready in irq", 32'(evt_ready), 0);
            end
            // drive inputs for the next edge
            wr_ready = !((cyc % 5) == 2 || (cyc % 13) < 2);
            if (mstate == 0 && idx < NEV) begin
                set_evt(idx);
                evt_valid = 1;
            end else if (mstate != 0) begin
                // R8: offered while busy, must be ignored
                evt_unit = 6'd1; evt_vec = 16'hFFFF; en_mask = 16'hFFFF;
                per_inst_mode = 0; evt_inst = 0; base_addr = 32'h0F00_0000;
                evt_valid = 1;
            end else begin
                evt_valid = 0;
                done = 1;
            end
            // advance the model through the coming edge
            case (mstate)
                0: if (evt_valid) begin idx++; model_accept(); end
                1: if (wr_ready) begin
                       void'(exp_q.pop_front());
                       if (exp_q.size() == 0) mstate = 2;
                   end
                default: mstate = 0;
            endcase
            if (cyc > WD) begin
                chk(1'b0, "R8 watchdog", 32'(cyc), WD);
                done = 1;
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule